// File: doc/BRIEF.md
# DRAM column data return pipeline

This block models the data-bus half of one DRAM channel. A command scheduler pushes column commands into it. Each command carries a request tag, the request's total byte count, a writeback flag and a bus direction. Every command waits in a delay line for the active bus latency: the CAS latency while the bus is in read mode, and the write latency while it is in write mode. The mode follows the direction of the most recently pushed command. After that wait, the command moves one data burst across the bus.

Each burst adds a fixed number of bytes to a running total kept per request tag. A request that needs several bursts is pushed once per burst. When the running total reaches the request's size, the request is finished. A finished writeback is retired with a one-cycle done strobe that carries its tag. Any other finished request is placed in a small reply queue, which a consumer drains through a valid/ready port. If the reply queue is full, the data return stalls, and the delay line then fills up and pushes back on the scheduler.

Top module: `dram_return_pipe`

## Requirements
- R1: After reset the delay line and the reply queue are empty, the bus is in read mode, `cmd_full` is 0, `rq_empty` is 1, and `rsp_valid` and `done_valid` are 0.
- R2: In read mode (`cmd_write`=0), a command pushed at clock edge e can first leave the delay line at edge e+RD_LAT. A single-burst read reply is therefore visible on `rsp_valid` right after that edge and not before.
- R3: A command with `cmd_write`=1 switches the bus to write mode. It leaves after WR_LAT edges, and later commands of the same direction keep that latency.
- R4: `cmd_full` is 1 exactly when the delay line holds at least (active latency + 1) entries, where the active latency depends on the current mode. The scheduler must not push while `cmd_full` is 1.
- R5: At most one entry leaves the delay line per edge, and only while the reply queue is not full. A full reply queue holds back the head entry and every entry behind it.
- R6: Each departure adds BURST_LEN*BUS_BYTES*DEVS_PER_CH bytes (16 by default) to the total for its tag. A departure that leaves the total below the request size has no effect on any output.
- R7: When a request with `cmd_wb`=1 completes, `done_valid` is 1 for one cycle, one edge after the departure, with `done_id` equal to its tag. Nothing is written to the reply queue.
- R8: When a request with `cmd_wb`=0 completes, its tag is written into the reply queue. `rsp_id` then presents replies in completion order.
- R9: The reply queue presents its head on `rsp_valid`/`rsp_id` and removes it on an edge where `rsp_valid` and `rsp_ready` are both 1. `rq_full` and `rq_empty` reflect the queue occupancy.
- R10: Entries leave the delay line strictly in push order. A short-latency write that sits behind a long-latency read waits for the read to leave first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Push one column command |
| cmd_write | input | 1 | Direction: 0 read, 1 write |
| cmd_wb | input | 1 | 1 marks a writeback access |
| cmd_id | input | ID_W | Request tag |
| cmd_size | input | SIZE_W | Total request size in bytes |
| cmd_full | output | 1 | Delay line full; no push allowed |
| rsp_valid | output | 1 | Reply queue head is valid |
| rsp_ready | input | 1 | Consumer takes the head reply |
| rsp_id | output | ID_W | Tag of the head reply |
| rq_full | output | 1 | Reply queue full |
| rq_empty | output | 1 | Reply queue empty |
| done_valid | output | 1 | Writeback completion strobe |
| done_id | output | ID_W | Tag of the completed writeback |

## Verification
The assertions assume that the scheduler never pushes while `cmd_full` is 1, and that every size is nonzero and no larger than what SIZE_W can hold. Under those assumptions, the delay-line bound and the reply-queue bound cannot be broken by the inputs themselves. The bench respects both assumptions: it only raises `cmd_valid` on a cycle where its own model predicts the line is not full, and it draws sizes only from one, two or three bursts. Random tags are allowed to repeat. Repeated tags exercise the shared per-tag byte totals.

// File: rtl/drp_pkg.sv
package drp_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } bus_dir_e;

  function automatic int umax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drp_delay_line.sv
module drp_delay_line
  import drp_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int SIZE_W = 8,
  parameter int RD_LAT = 5,
  parameter int WR_LAT = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  bus_dir_e          push_dir_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [SIZE_W-1:0] push_size_i,
  input  logic              push_wb_i,
  input  logic              pop_i,
  output logic              head_ok_o,
  output logic [ID_W-1:0]   head_id_o,
  output logic [SIZE_W-1:0] head_size_o,
  output logic              head_wb_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam int MAX_LAT = umax(RD_LAT, WR_LAT);
  localparam int DEPTH   = MAX_LAT + 1;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int HOLD_W  = $clog2(MAX_LAT + 1);

  logic [ID_W-1:0]   id_mem   [DEPTH];
  logic [SIZE_W-1:0] size_mem [DEPTH];
  logic              wb_mem   [DEPTH];
  logic [HOLD_W-1:0] hold_q   [DEPTH];

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  bus_dir_e          mode_q;
  logic [HOLD_W-1:0] push_hold;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // remaining wait for a new entry: latency of its own direction, minus the push edge
  assign push_hold = (push_dir_i == DIR_WRITE) ? HOLD_W'(WR_LAT - 1) : HOLD_W'(RD_LAT - 1);

  // payload storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (push_i) begin
      id_mem[wr_ptr]   <= push_id_i;
      size_mem[wr_ptr] <= push_size_i;
      wb_mem[wr_ptr]   <= push_wb_i;
    end
  end

  // per-slot countdown to eligibility
  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (rst) begin
        hold_q[s] <= '0;
      end else if (push_i && (wr_ptr == PTR_W'(s))) begin
        hold_q[s] <= push_hold;
      end else if (hold_q[s] != '0) begin
        hold_q[s] <= hold_q[s] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      mode_q <= DIR_READ;
    end else begin
      if (push_i) begin
        wr_ptr <= step(wr_ptr);
        mode_q <= push_dir_i;
      end
      if (pop_i) begin
        rd_ptr <= step(rd_ptr);
      end
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_ok_o   = (cnt_q != '0) && (hold_q[rd_ptr] == '0);
  assign head_id_o   = id_mem[rd_ptr];
  assign head_size_o = size_mem[rd_ptr];
  assign head_wb_o   = wb_mem[rd_ptr];
  assign full_o      = cnt_q >= ((mode_q == DIR_WRITE) ? CNT_W'(WR_LAT + 1) : CNT_W'(RD_LAT + 1));
  assign count_o     = cnt_q;

endmodule

// File: rtl/drp_byte_tally.sv
module drp_byte_tally #(
  parameter int ID_W        = 4,
  parameter int SIZE_W      = 8,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              complete_o
);

  localparam int ENTRIES = 1 << ID_W;
  localparam int TW      = SIZE_W + 1;

  logic [TW-1:0] tally_q [ENTRIES];
  logic [TW-1:0] sum;

  assign sum        = tally_q[id_i] + TW'(BURST_BYTES);
  assign complete_o = sum >= {1'b0, size_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < ENTRIES; t++) begin
        tally_q[t] <= '0;
      end
    end else if (step_i) begin
      tally_q[id_i] <= complete_o ? '0 : sum;
    end
  end

endmodule

// File: rtl/drp_reply_fifo.sv
module drp_reply_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [W-1:0]     data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr] <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full_o  = cnt_q == CNT_W'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign valid_o = !empty_o;
  assign data_o  = mem[rd_ptr];
  assign count_o = cnt_q;

endmodule

// File: rtl/dram_return_pipe.sv
module dram_return_pipe
  import drp_pkg::*;
#(
  parameter int ID_W        = 4,
  parameter int SIZE_W      = 8,
  parameter int BURST_LEN   = 4,
  parameter int BUS_BYTES   = 4,
  parameter int DEVS_PER_CH = 1,
  parameter int RD_LAT      = 5,
  parameter int WR_LAT      = 2,
  parameter int RQ_DEPTH    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_wb,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [SIZE_W-1:0] cmd_size,
  output logic              cmd_full,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic              rq_full,
  output logic              rq_empty,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id
);

  localparam int BURST_BYTES = BURST_LEN * BUS_BYTES * DEVS_PER_CH;
  localparam int DL_DEPTH    = umax(RD_LAT, WR_LAT) + 1;
  localparam int DL_CNT_W    = $clog2(DL_DEPTH + 1);
  localparam int RQ_CNT_W    = $clog2(RQ_DEPTH + 1);

  logic              head_ok, head_wb, complete, pop_go, rq_push;
  logic [ID_W-1:0]   head_id;
  logic [SIZE_W-1:0] head_size;
  logic [DL_CNT_W-1:0] dl_count;
  logic [RQ_CNT_W-1:0] rq_count;

  drp_delay_line #(
    .ID_W(ID_W), .SIZE_W(SIZE_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .CNT_W(DL_CNT_W)
  ) u_line (
    .clk         (clk),
    .rst         (rst),
    .push_i      (cmd_valid),
    .push_dir_i  (bus_dir_e'(cmd_write)),
    .push_id_i   (cmd_id),
    .push_size_i (cmd_size),
    .push_wb_i   (cmd_wb),
    .pop_i       (pop_go),
    .head_ok_o   (head_ok),
    .head_id_o   (head_id),
    .head_size_o (head_size),
    .head_wb_o   (head_wb),
    .full_o      (cmd_full),
    .count_o     (dl_count)
  );

  // one burst leaves per edge, only when the reply queue has room
  assign pop_go  = head_ok && !rq_full;
  assign rq_push = pop_go && complete && !head_wb;

  drp_byte_tally #(
    .ID_W(ID_W), .SIZE_W(SIZE_W), .BURST_BYTES(BURST_BYTES)
  ) u_tally (
    .clk        (clk),
    .rst        (rst),
    .step_i     (pop_go),
    .id_i       (head_id),
    .size_i     (head_size),
    .complete_o (complete)
  );

  drp_reply_fifo #(
    .W(ID_W), .DEPTH(RQ_DEPTH), .CNT_W(RQ_CNT_W)
  ) u_reply (
    .clk     (clk),
    .rst     (rst),
    .push_i  (rq_push),
    .data_i  (head_id),
    .pop_i   (rsp_ready),
    .valid_o (rsp_valid),
    .data_o  (rsp_id),
    .full_o  (rq_full),
    .empty_o (rq_empty),
    .count_o (rq_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid <= 1'b0;
      done_id    <= '0;
    end else begin
      done_valid <= pop_go && complete && head_wb;
      if (pop_go && complete && head_wb) begin
        done_id <= head_id;
      end
    end
  end

endmodule

// File: rtl/drp_checker.sv
module drp_checker #(
  parameter int DL_CNT_W = 3,
  parameter int RQ_CNT_W = 3,
  parameter int DL_DEPTH = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rq_full,
  input logic                rq_empty,
  input logic                done_valid,
  input logic [DL_CNT_W-1:0] dl_count,
  input logic [RQ_CNT_W-1:0] rq_count
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rq_empty && !done_valid && (dl_count == '0)));

  // R4
  dl_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    dl_count <= DL_CNT_W'(DL_DEPTH));

  // R5
  rq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_full && !(rsp_valid && rsp_ready)) |=> rq_full);

  // R7
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> ($past(dl_count) != '0));

  // R8
  rq_growth_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, rq_count} <= ({1'b0, $past(rq_count)} + (RQ_CNT_W + 1)'(1)));

endmodule

bind dram_return_pipe drp_checker #(
  .DL_CNT_W(DL_CNT_W), .RQ_CNT_W(RQ_CNT_W), .DL_DEPTH(DL_DEPTH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rq_full    (rq_full),
  .rq_empty   (rq_empty),
  .done_valid (done_valid),
  .dl_count   (dl_count),
  .rq_count   (rq_count)
);

// File: tb/sim_dram_return_pipe.sv
`timescale 1ns/1ps
module sim_dram_return_pipe;

  localparam int ID_W = 4;
  localparam int SIZE_W = 8;
  localparam int RD_LAT = 5;
  localparam int WR_LAT = 2;
  localparam int RQ_DEPTH = 4;
  localparam int BURST = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_wb = 1'b0, rsp_ready = 1'b0;
  logic [ID_W-1:0] cmd_id = '0;
  logic [SIZE_W-1:0] cmd_size = '0;
  logic cmd_full, rsp_valid, rq_full, rq_empty, done_valid;
  logic [ID_W-1:0] rsp_id, done_id;

  always #2 clk = ~clk;

  dram_return_pipe #(
    .ID_W(ID_W), .SIZE_W(SIZE_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .RQ_DEPTH(RQ_DEPTH)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_wb(cmd_wb),
    .cmd_id(cmd_id), .cmd_size(cmd_size), .cmd_full(cmd_full), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rq_full(rq_full), .rq_empty(rq_empty),
    .done_valid(done_valid), .done_id(done_id)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_id[$], m_size[$], m_wb[$], m_rdy[$];
  int m_rq[$];
  int m_tally[1 << ID_W];
  int cyc;
  bit m_write_mode;
  bit e_done;
  int e_done_id;
  bit rq_was_full;
  int p_id, p_size, p_wb;

  function automatic bit exp_full();
    return m_id.size() >= ((m_write_mode ? WR_LAT : RD_LAT) + 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_id.delete(); m_size.delete(); m_wb.delete(); m_rdy.delete(); m_rq.delete();
      foreach (m_tally[k]) m_tally[k] = 0;
      cyc = 0; m_write_mode = 0; e_done = 0; e_done_id = 0;
    end else begin
      rq_was_full = m_rq.size() >= RQ_DEPTH;
      e_done = 0;
      if (rsp_ready && m_rq.size() > 0) void'(m_rq.pop_front());
      if (m_id.size() > 0 && m_rdy[0] <= cyc && !rq_was_full) begin
        p_id = m_id.pop_front(); p_size = m_size.pop_front(); p_wb = m_wb.pop_front();
        void'(m_rdy.pop_front());
        m_tally[p_id] += BURST;
        if (m_tally[p_id] >= p_size) begin
          m_tally[p_id] = 0;
          if (p_wb != 0) begin e_done = 1; e_done_id = p_id; end
          else m_rq.push_back(p_id);
        end
      end
      if (cmd_valid) begin
        m_write_mode = cmd_write;
        m_id.push_back(int'(cmd_id)); m_size.push_back(int'(cmd_size));
        m_wb.push_back(int'(cmd_wb));
        m_rdy.push_back(cyc + (m_write_mode ? WR_LAT : RD_LAT));
      end
      cyc++;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R4 cmd_full", int'(cmd_full), int'(exp_full()));
      chk("R9 rq_empty", int'(rq_empty), int'(m_rq.size() == 0));
      chk("R9 rq_full", int'(rq_full), int'(m_rq.size() >= RQ_DEPTH));
      chk("R8 rsp_valid", int'(rsp_valid), int'(m_rq.size() > 0));
      if (m_rq.size() > 0) chk("R8 rsp_id", int'(rsp_id), m_rq[0]);
      chk("R7 done_valid", int'(done_valid), int'(e_done));
      if (e_done) chk("R7 done_id", int'(done_id), e_done_id);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input bit wr, input bit wb, input int id, input int sz);
    cmd_valid = 1'b1; cmd_write = wr; cmd_wb = wb;
    cmd_id = ID_W'(id); cmd_size = SIZE_W'(sz);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic take();
    rsp_ready = 1'b1;
    tick();
    rsp_ready = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (5) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 cmd_full", int'(cmd_full), 0);
    chk("R1 rq_empty", int'(rq_empty), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 done_valid", int'(done_valid), 0);

    // R2 read latency
    push(0, 0, 3, 16);
    repeat (RD_LAT - 1) tick();
    chk("R2 early reply", int'(rsp_valid), 0);
    tick();
    chk("R2 reply valid", int'(rsp_valid), 1);
    chk("R2 reply id", int'(rsp_id), 3);
    take();

    // R3 write latency after mode flip
    push(1, 0, 4, 16);
    repeat (WR_LAT - 1) tick();
    chk("R3 early reply", int'(rsp_valid), 0);
    tick();
    chk("R3 reply valid", int'(rsp_valid), 1);
    chk("R3 reply id", int'(rsp_id), 4);
    take();

    // R6 / R7 two-burst writeback
    push(1, 1, 7, 32);
    push(1, 1, 7, 32);
    tick();
    chk("R6 partial no done", int'(done_valid), 0);
    tick();
    chk("R7 done strobe", int'(done_valid), 1);
    chk("R7 done tag", int'(done_id), 7);
    tick();
    chk("R7 single pulse", int'(done_valid), 0);
    chk("R7 no reply", int'(rq_empty), 1);

    // R5 fill reply queue, R4 fill delay line
    for (int k = 8; k < 12; k++) push(0, 0, k, 16);
    repeat (RD_LAT + 3) tick();
    chk("R5 reply queue full", int'(rq_full), 1);
    for (int k = 0; k < 6; k++) begin
      chk("R4 not yet full", int'(cmd_full), 0);
      push(0, 0, k, 16);
    end
    chk("R4 line full", int'(cmd_full), 1);
    repeat (10) tick();
    chk("R5 stalled head", int'(rsp_id), 8);
    chk("R5 still full", int'(cmd_full), 1);
    for (int k = 0; k < 10; k++) begin
      chk("R10 drain valid", int'(rsp_valid), 1);
      chk("R10 drain order", int'(rsp_id), (k < 4) ? (8 + k) : (k - 4));
      take();
    end

    // R10 write behind read
    push(0, 0, 12, 16);
    push(1, 0, 13, 16);
    for (int i = 0; i < 20 && !rsp_valid; i++) tick();
    chk("R10 first out", int'(rsp_id), 12);
    take();
    for (int i = 0; i < 20 && !rsp_valid; i++) tick();
    chk("R10 second out", int'(rsp_id), 13);
    take();

    // mixed random traffic, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      cmd_valid = (($urandom % 3) == 0) && !exp_full();
      cmd_write = $urandom % 2;
      cmd_wb    = (($urandom % 4) == 0);
      cmd_id    = ID_W'($urandom % (1 << ID_W));
      cmd_size  = SIZE_W'(BURST * (1 + ($urandom % 3)));
      rsp_ready = $urandom % 2;
      tick();
    end
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    repeat (40) tick();
    chk("R9 drained empty", int'(rq_empty), 1);
    chk("R4 drained not full", int'(cmd_full), 0);
    summary();
  end

endmodule